// File: doc/BRIEF.md
# Sound Processor I/O Page with Boot-ROM Overlay

This block sits between a small sound processor's CPU bus and three neighbours: an external 64 KB synchronous RAM, a 128-entry DSP register file and a bank of three timers. It claims sixteen addresses at 0x00F0 to 0x00FF for control registers and routes every other access to RAM. The exception is the top 64 bytes, 0xFFC0 to 0xFFFF, where a boot ROM can be mapped over the RAM for reads.

A control register carries the timer enables, two port-clear strobes and the overlay enable. The DSP register file is reached indirectly. The CPU first writes an index byte, then reads or writes a data byte that is forwarded to the DSP. Four port bytes written by the CPU are presented to the host on a 32-bit output.

Every read request is answered exactly one cycle later. A response state machine records, in the request cycle, where the answer will come from. Its states are `ST_IDLE` (no response due), `ST_RAM` (pass the RAM read data through), `ST_DSP` (pass the DSP read data through) and `ST_LOCAL` (return a byte captured from a register or the ROM). Its transitions are:
- A read of RAM, or of the ROM window with the overlay off, goes to `ST_RAM`.
- A read of the DSP data address goes to `ST_DSP`.
- A read of any other page register, or of the ROM window with the overlay on, goes to `ST_LOCAL`.
- A write or an idle cycle goes to `ST_IDLE`.

These transitions are taken from any state, so reads may be issued back to back.

Top module: `snd_io_page`

## Requirements
- R1: After reset, the control register reads 0x80. `tmr_en` is 0, `port_out` is 0, `bus_rvalid` is 0 and the DSP index reads 0.
- R2: A read request is answered with `bus_rvalid` high in the next cycle only. `bus_rvalid` is low in every cycle that does not follow a read request.
- R3: A write to 0x00F1 stores the control byte. Bits 2:0 drive `tmr_en[2:0]` from the next cycle. A read of 0x00F1 returns the stored byte.
- R4: Writes to 0x00F4 to 0x00F7 set port byte 0 to 3, shown on `port_out[8*i+7:8*i]`, and reads return them. A control write with bit 4 set clears bytes 0 and 1. A control write with bit 5 set clears bytes 2 and 3.
- R5: When control bit 7 is 1 at the request cycle, reads of 0xFFC0 to 0xFFFF return ROM bytes. When it is 0, they return RAM. The response reflects the overlay state of the request cycle, even if the next request changes it.
- R6: Writes to 0xFFC0 to 0xFFFF always assert `ram_we`, whatever the overlay state.
- R7: The default ROM holds 0xC0 at 0xFFFE, 0xFF at 0xFFFF and 0x00 at every other address.
- R8: 0x00F2 is the DSP index register, readable and writable. A read of 0x00F3 returns the DSP register selected by index bits 6:0.
- R9: A write to 0x00F3 asserts `dsp_we` only when the index is below 128. Otherwise the write is dropped.
- R10: A write to 0x00F0 changes nothing and asserts neither `ram_we` nor `dsp_we`. A read of it returns 0x00.
- R11: 0x00F8 to 0x00FF and every address outside the page and the overlaid window are plain RAM, both readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | CPU access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 8 | Read response data |
| ram_addr | output | 16 | RAM address |
| ram_re | output | 1 | RAM read enable (data one cycle later) |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| dsp_addr | output | 7 | DSP register index |
| dsp_re | output | 1 | DSP read enable (data one cycle later) |
| dsp_we | output | 1 | DSP write enable |
| dsp_wdata | output | 8 | DSP write data |
| dsp_rdata | input | 8 | DSP read data |
| tmr_en | output | 3 | Timer enables |
| port_out | output | 32 | Port bytes to the host |

## Verification
Two functions can meet in the same cycle: delivering the answer to an overlaid-ROM read, and accepting a control write that switches the overlay off. The bench issues a read of 0xFFFF and, in the very next cycle, a control write that clears bit 7. It then reads 0xFFFF again. The first answer must be the ROM byte and the second must be the RAM byte. The same pairing is used for a port-clearing control write against the response of a port read in flight, with every output compared to a behavioural model on every clock.

// File: rtl/snd_io_pkg.sv
package snd_io_pkg;

    // Address classes seen by the page logic.
    typedef enum logic [2:0] {
        RG_RAM,
        RG_ROM,
        RG_TEST,
        RG_CTRL,
        RG_DADDR,
        RG_DDATA,
        RG_PORT
    } region_t;

    // Source of the read response due in the current cycle.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RAM,
        ST_DSP,
        ST_LOCAL
    } rsp_state_t;

    // Control register bit positions.
    localparam int CTRL_CLR_BASE = 4;  // bit 4: clear ports 0/1, bit 5: ports 2/3
    localparam int CTRL_ROM_BIT  = 7;

endpackage

// File: rtl/snd_io_decode.sv
module snd_io_decode
    import snd_io_pkg::*;
#(
    parameter int                  ADDR_W    = 16,
    parameter int                  ROM_BYTES = 64,
    parameter logic [ADDR_W-1:0]   PAGE_BASE = 'h00F0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'((1 << ADDR_W) - ROM_BYTES);

    logic in_page;
    assign in_page = (addr[ADDR_W-1:4] == PAGE_BASE[ADDR_W-1:4]);

    always_comb begin
        region = RG_RAM;
        if (in_page) begin
            case (addr[3:0])
                4'h0:                      region = RG_TEST;
                4'h1:                      region = RG_CTRL;
                4'h2:                      region = RG_DADDR;
                4'h3:                      region = RG_DDATA;
                4'h4, 4'h5, 4'h6, 4'h7:    region = RG_PORT;
                default:                   region = RG_RAM;
            endcase
        end else if (addr >= ROM_BASE) begin
            region = RG_ROM;
        end
    end

endmodule

// File: rtl/snd_boot_rom.sv
module snd_boot_rom #(
    parameter int DATA_W    = 8,
    parameter int ROM_BYTES = 64,
    parameter logic [ROM_BYTES*DATA_W-1:0] INIT =
        {DATA_W'(8'hFF), DATA_W'(8'hC0), {((ROM_BYTES-2)*DATA_W){1'b0}}},
    localparam int IDX_W = $clog2(ROM_BYTES)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] rom_arr [ROM_BYTES];

    for (genvar i = 0; i < ROM_BYTES; i++) begin : g_byte
        assign rom_arr[i] = INIT[i*DATA_W +: DATA_W];
    end

    assign data = rom_arr[idx];

endmodule

// File: rtl/snd_io_regs.sv
module snd_io_regs
    import snd_io_pkg::*;
#(
    parameter int              DATA_W     = 8,
    parameter int              N_TIMERS   = 3,
    parameter int              N_PORTS    = 4,
    parameter logic [DATA_W-1:0] CTRL_RESET = 8'h80,
    localparam int             PIW        = $clog2(N_PORTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_ctrl,
    input  logic                      wr_daddr,
    input  logic                      wr_port,
    input  logic [PIW-1:0]            port_idx,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         ctrl_q,
    output logic [DATA_W-1:0]         daddr_q,
    output logic [N_PORTS*DATA_W-1:0] port_q,
    output logic [N_TIMERS-1:0]       tmr_en
);
    logic [DATA_W-1:0] port_r [N_PORTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            daddr_q <= '0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= wdata;
            if (wr_daddr) daddr_q <= wdata;
        end
    end

    // Ports pair up on clear strobes: ports 2k and 2k+1 share bit CLR_BASE+k.
    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                port_r[i] <= '0;
            end else if (wr_ctrl && wdata[CTRL_CLR_BASE + i/2]) begin
                port_r[i] <= '0;
            end else if (wr_port && port_idx == PIW'(i)) begin
                port_r[i] <= wdata;
            end
        end
        assign port_q[i*DATA_W +: DATA_W] = port_r[i];
    end

    assign tmr_en = ctrl_q[N_TIMERS-1:0];

    assert_timer_en_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> tmr_en == $past(wdata[N_TIMERS-1:0]));

    assert_low_ports_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTRL_CLR_BASE]) |=> (port_r[0] == '0 && port_r[1] == '0));

    assert_high_ports_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTRL_CLR_BASE+1]) |=> (port_r[2] == '0 && port_r[3] == '0));

endmodule

// File: rtl/snd_io_page.sv
module snd_io_page
    import snd_io_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter int                ROM_BYTES  = 64,
    parameter int                N_TIMERS   = 3,
    parameter int                N_PORTS    = 4,
    parameter int                DSP_REGS   = 128,
    parameter logic [ADDR_W-1:0] PAGE_BASE  = 'h00F0,
    parameter logic [DATA_W-1:0] CTRL_RESET = 8'h80,
    localparam int               ROM_IW     = $clog2(ROM_BYTES),
    localparam int               DSP_AW     = $clog2(DSP_REGS),
    localparam int               PIW        = $clog2(N_PORTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic                      bus_rvalid,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [ADDR_W-1:0]         ram_addr,
    output logic                      ram_re,
    output logic                      ram_we,
    output logic [DATA_W-1:0]         ram_wdata,
    input  logic [DATA_W-1:0]         ram_rdata,
    output logic [DSP_AW-1:0]         dsp_addr,
    output logic                      dsp_re,
    output logic                      dsp_we,
    output logic [DATA_W-1:0]         dsp_wdata,
    input  logic [DATA_W-1:0]         dsp_rdata,
    output logic [N_TIMERS-1:0]       tmr_en,
    output logic [N_PORTS*DATA_W-1:0] port_out
);
    region_t            region;
    rsp_state_t         state_q, state_d;
    logic [DATA_W-1:0]  local_q, local_d;
    logic [DATA_W-1:0]  ctrl_q, daddr_q, rom_byte, port_byte;
    logic               is_rd, is_wr, overlay_on;
    logic               wr_ctrl, wr_daddr, wr_port;

    snd_io_decode #(
        .ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .PAGE_BASE(PAGE_BASE)
    ) u_decode (
        .addr(bus_addr), .region(region)
    );

    snd_boot_rom #(
        .DATA_W(DATA_W), .ROM_BYTES(ROM_BYTES)
    ) u_rom (
        .idx(bus_addr[ROM_IW-1:0]), .data(rom_byte)
    );

    snd_io_regs #(
        .DATA_W(DATA_W), .N_TIMERS(N_TIMERS), .N_PORTS(N_PORTS), .CTRL_RESET(CTRL_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_ctrl), .wr_daddr(wr_daddr), .wr_port(wr_port),
        .port_idx(bus_addr[PIW-1:0]), .wdata(bus_wdata),
        .ctrl_q(ctrl_q), .daddr_q(daddr_q), .port_q(port_out), .tmr_en(tmr_en)
    );

    assign is_rd      = bus_req && !bus_we;
    assign is_wr      = bus_req && bus_we;
    assign overlay_on = ctrl_q[CTRL_ROM_BIT];
    assign port_byte  = port_out[bus_addr[PIW-1:0]*DATA_W +: DATA_W];

    // Write routing: the ROM window always writes through to RAM.
    assign ram_addr  = bus_addr;
    assign ram_wdata = bus_wdata;
    assign ram_we    = is_wr && (region == RG_RAM || region == RG_ROM);
    assign wr_ctrl   = is_wr && region == RG_CTRL;
    assign wr_daddr  = is_wr && region == RG_DADDR;
    assign wr_port   = is_wr && region == RG_PORT;

    assign dsp_addr  = daddr_q[DSP_AW-1:0];
    assign dsp_wdata = bus_wdata;
    assign dsp_we    = is_wr && region == RG_DDATA && (daddr_q < DATA_W'(DSP_REGS));

    // Next-state and read-side strobes.
    always_comb begin
        state_d = ST_IDLE;
        local_d = local_q;
        ram_re  = 1'b0;
        dsp_re  = 1'b0;
        if (is_rd) begin
            unique case (region)
                RG_RAM: begin
                    ram_re  = 1'b1;
                    state_d = ST_RAM;
                end
                RG_ROM: begin
                    if (overlay_on) begin
                        local_d = rom_byte;
                        state_d = ST_LOCAL;
                    end else begin
                        ram_re  = 1'b1;
                        state_d = ST_RAM;
                    end
                end
                RG_TEST: begin
                    local_d = '0;
                    state_d = ST_LOCAL;
                end
                RG_CTRL: begin
                    local_d = ctrl_q;
                    state_d = ST_LOCAL;
                end
                RG_DADDR: begin
                    local_d = daddr_q;
                    state_d = ST_LOCAL;
                end
                RG_PORT: begin
                    local_d = port_byte;
                    state_d = ST_LOCAL;
                end
                RG_DDATA: begin
                    dsp_re  = 1'b1;
                    state_d = ST_DSP;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            local_q <= '0;
        end else begin
            state_q <= state_d;
            local_q <= local_d;
        end
    end

    // Outputs.
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            ST_IDLE:  begin bus_rvalid = 1'b0; bus_rdata = '0;        end
            ST_RAM:   begin bus_rvalid = 1'b1; bus_rdata = ram_rdata; end
            ST_DSP:   begin bus_rvalid = 1'b1; bus_rdata = dsp_rdata; end
            ST_LOCAL: begin bus_rvalid = 1'b1; bus_rdata = local_q;   end
            default:  begin bus_rvalid = 1'b0; bus_rdata = '0;        end
        endcase
    end

    assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> bus_rvalid);

    assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !bus_rvalid);

    assert_rom_write_reaches_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && bus_addr >= ADDR_W'((1 << ADDR_W) - ROM_BYTES)) |-> ram_we);

    assert_overlay_blocks_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && region == RG_ROM && overlay_on) |-> !ram_re);

    assert_dsp_write_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_we |-> daddr_q < DATA_W'(DSP_REGS));

    assert_test_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && bus_addr == PAGE_BASE) |-> (!ram_we && !dsp_we && !wr_ctrl));

endmodule

// File: tb/snd_io_page_tb.sv
`timescale 1ns/1ps
module snd_io_page_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_req = 0, bus_we = 0;
    logic [15:0] bus_addr = 0;
    logic [7:0]  bus_wdata = 0;
    logic        bus_rvalid;
    logic [7:0]  bus_rdata;
    logic [15:0] ram_addr;
    logic        ram_re, ram_we;
    logic [7:0]  ram_wdata, ram_rdata;
    logic [6:0]  dsp_addr;
    logic        dsp_re, dsp_we;
    logic [7:0]  dsp_wdata, dsp_rdata;
    logic [2:0]  tmr_en;
    logic [31:0] port_out;

    always #2.5 clk = ~clk;

    snd_io_page u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .dsp_addr(dsp_addr), .dsp_re(dsp_re), .dsp_we(dsp_we),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .tmr_en(tmr_en), .port_out(port_out)
    );

    // Environment: sparse RAM and DSP register file, one-cycle read latency.
    logic [7:0] ram_mem [int];
    logic [7:0] dsp_mem [128];
    always @(posedge clk) begin
        if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
        if (ram_re) ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
        if (dsp_we) dsp_mem[dsp_addr] = dsp_wdata;
        if (dsp_re) dsp_rdata <= dsp_mem[dsp_addr];
    end

    // Reference model state.
    int         nchk = 0, nfail = 0;
    bit         done = 0;
    logic [7:0] m_ctrl = 8'h80, m_daddr = 8'h00;
    logic [7:0] m_port [4] = '{default: 8'h00};
    logic [7:0] m_ram [int];
    logic [7:0] m_dsp [128];
    bit         e_valid = 0;
    logic [7:0] e_data = 0;
    string      e_tag = "R2";

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ram_get(int a);
        return m_ram.exists(a) ? m_ram[a] : 8'h00;
    endfunction

    function automatic logic [7:0] rom_get(int a);
        if (a == 16'hFFFE) return 8'hC0;
        if (a == 16'hFFFF) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] model_read(int a);
        if (a >= 16'h00F0 && a <= 16'h00F7) begin
            case (a & 15)
                0: return 8'h00;
                1: return m_ctrl;
                2: return m_daddr;
                3: return m_dsp[m_daddr & 8'h7F];
                default: return m_port[(a & 15) - 4];
            endcase
        end
        if (a >= 16'hFFC0 && m_ctrl[7]) return rom_get(a);
        return ram_get(a);
    endfunction

    // One bus cycle: compare the previous cycle's results, then issue a new request.
    task automatic step(bit rq, bit we, int a, int d, string tag);
        bit pg, exp_rwe, exp_dwe;
        @(negedge clk);
        check({e_tag, " rvalid"}, bus_rvalid, e_valid);
        if (e_valid) check({e_tag, " rdata"}, bus_rdata, e_data);
        check("R3 tmr_en", tmr_en, m_ctrl[2:0]);
        check("R4 port_out", port_out, {m_port[3], m_port[2], m_port[1], m_port[0]});
        bus_req = rq; bus_we = we; bus_addr = 16'(a); bus_wdata = 8'(d);
        #1;
        pg      = (a >= 16'h00F0 && a <= 16'h00F7);
        exp_rwe = rq && we && !pg;
        exp_dwe = rq && we && a == 16'h00F3 && m_daddr < 128;
        check({tag, " ram_we"}, ram_we, exp_rwe);
        check({tag, " dsp_we"}, dsp_we, exp_dwe);
        e_valid = rq && !we;
        e_tag   = tag;
        if (e_valid) e_data = model_read(a);
        if (rq && we) begin
            if (!pg) m_ram[a] = 8'(d);
            else begin
                case (a & 15)
                    1: begin
                        m_ctrl = 8'(d);
                        if (d & 16) begin m_port[0] = 0; m_port[1] = 0; end
                        if (d & 32) begin m_port[2] = 0; m_port[3] = 0; end
                    end
                    2: m_daddr = 8'(d);
                    3: if (m_daddr < 128) m_dsp[m_daddr] = 8'(d);
                    4, 5, 6, 7: m_port[(a & 15) - 4] = 8'(d);
                    default: ;
                endcase
            end
        end
    endtask

    task automatic wr(int a, int d, string tag); step(1, 1, a, d, tag); endtask
    task automatic rd(int a, string tag);        step(1, 0, a, 0, tag); endtask
    task automatic idle();                        step(0, 0, 0, 0, "R2"); endtask

    initial begin
        for (int i = 0; i < 128; i++) begin dsp_mem[i] = 8'(i * 3); m_dsp[i] = 8'(i * 3); end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rvalid", bus_rvalid, 0);
        check("R1 tmr_en", tmr_en, 0);
        check("R1 port_out", port_out, 0);
        rst_n = 1;
        rd(16'h00F1, "R1 ctrl");
        rd(16'h00F2, "R1 daddr");
        idle();
        // Timer enables and control read-back
        wr(16'h00F1, 8'h87, "R3");
        rd(16'h00F1, "R3");
        wr(16'h00F1, 8'h82, "R3");
        rd(16'h00F1, "R3");
        // Port bytes and clear strobes
        wr(16'h00F4, 8'h11, "R4"); wr(16'h00F5, 8'h22, "R4");
        wr(16'h00F6, 8'h33, "R4"); wr(16'h00F7, 8'h44, "R4");
        rd(16'h00F4, "R4"); rd(16'h00F7, "R4");
        rd(16'h00F5, "R4");
        wr(16'h00F1, 8'h95, "R4");     // clear ports 0/1 while port read answers
        rd(16'h00F5, "R4"); rd(16'h00F6, "R4");
        wr(16'h00F1, 8'hA1, "R4");
        wr(16'h00F4, 8'h5C, "R4"); wr(16'h00F6, 8'h6D, "R4");
        wr(16'h00F1, 8'hB0, "R4");
        rd(16'h00F4, "R4"); idle();
        // Plain RAM, including the tail of the page
        wr(16'h1234, 8'h5A, "R11"); rd(16'h1234, "R11");
        for (int a = 16'h00F8; a <= 16'h00FF; a++) wr(a, a ^ 8'h3C, "R11");
        for (int a = 16'h00F8; a <= 16'h00FF; a++) rd(a, "R11");
        wr(16'h0000, 8'h99, "R11"); rd(16'h0000, "R11"); rd(16'hFFBF, "R11");
        // Overlay and default ROM contents
        wr(16'h00F1, 8'h80, "R5");
        rd(16'hFFFE, "R7"); rd(16'hFFFF, "R7"); rd(16'hFFC0, "R7"); rd(16'hFFD5, "R7");
        wr(16'hFFFE, 8'hAB, "R6"); wr(16'hFFFF, 8'h77, "R6"); wr(16'hFFC0, 8'h12, "R6");
        rd(16'hFFFE, "R5"); rd(16'hFFC0, "R5");
        rd(16'hFFFF, "R5");            // answered while overlay is turned off
        wr(16'h00F1, 8'h00, "R5");
        rd(16'hFFFF, "R5"); rd(16'hFFFE, "R5"); rd(16'hFFC0, "R5");
        wr(16'hFFE0, 8'h4E, "R6"); rd(16'hFFE0, "R6");
        wr(16'h00F1, 8'h80, "R5"); rd(16'hFFE0, "R5"); idle();
        // DSP window
        wr(16'h00F2, 8'h05, "R8"); wr(16'h00F3, 8'h9C, "R8");
        rd(16'h00F3, "R8"); rd(16'h00F2, "R8");
        wr(16'h00F2, 8'h7F, "R8"); wr(16'h00F3, 8'hE1, "R8"); rd(16'h00F3, "R8");
        wr(16'h00F2, 8'h85, "R9"); wr(16'h00F3, 8'h11, "R9");
        rd(16'h00F3, "R9");            // index masked to 5: old value kept
        wr(16'h00F2, 8'hFF, "R9"); wr(16'h00F3, 8'h22, "R9"); rd(16'h00F3, "R9");
        rd(16'h00F2, "R8"); idle();
        // Test register
        wr(16'h00F0, 8'hFF, "R10"); rd(16'h00F0, "R10"); rd(16'h00F1, "R10");
        wr(16'h00F0, 8'h00, "R10"); rd(16'h00F0, "R10");
        idle(); idle();
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R2: watchdog expired, actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule